// File: doc/BRIEF.md
# Run-time tapped delay line

This block delays a parallel word by a number of clock-enabled cycles that can be changed while it runs. Every enabled clock edge moves each stored word one slot down a chain of registers. A combinational selector, steered by a small depth input, picks one slot and drives it out. This lets a designer even out the latency of unequal pipeline branches without re-synthesis. The last slot is always driven on a separate port, so two instances can be chained for longer delays. A third output can add one more register after the selector.

The line takes one word on each edge where the enable is high, and its outputs are sampled by the consumer in the same way. It has no back-pressure, so holding the enable low is the only way to stall it. When the enable is low, every slot keeps its value. Changing the depth input moves the tap at once and does not disturb the stored words.

Top module: `dly_line`

## Requirements
- R1: While `rst_n` is low, every slot and the extra output register are cleared, so `tap_o`, `casc_o` and `tap_q_o` read zero. On the first edge after reset is released, `casc_o` still reads zero.
- R2: On a rising edge with `ce_i` high, slot 0 captures `din_i` and each slot k captures slot k-1.
- R3: On a rising edge with `ce_i` low, all slots and the extra register keep their values. With the depth unchanged, no output moves.
- R4: With depth value N on `depth_i`, `tap_o` shows the word that was on `din_i` N+1 enabled edges earlier, so the delay covers 1 to STAGES enabled edges. Slots not yet filled since reset read zero.
- R5: A change on `depth_i` shows on `tap_o` in the same cycle, with no clock edge needed, and the stored words are not lost. Moving the depth up by one across an enabled edge keeps the same word on `tap_o`.
- R6: `casc_o` always shows the last slot, which is the word from STAGES enabled edges earlier, whatever the depth. With depth STAGES-1, `tap_o` equals `casc_o`.
- R7: With EXTRA_FF=1, `tap_q_o` loads `tap_o` on each enabled edge and holds it otherwise, which gives a delay of N+2 enabled edges. With EXTRA_FF=0, `tap_q_o` equals `tap_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| ce_i | input | 1 | Shift enable; when low, the line holds |
| din_i | input | WIDTH | Word entering slot 0 |
| depth_i | input | DEPTH_W | Tap select; value N gives a delay of N+1 |
| tap_o | output | WIDTH | Word at the selected slot (combinational) |
| casc_o | output | WIDTH | Last slot, for chaining a further instance |
| tap_q_o | output | WIDTH | Tap word after the optional extra register |

## Verification
A wrong bit in slot k appears on `tap_o` at once while the depth points at k. It appears on `casc_o` after STAGES-1-k further enabled edges, because the bad word is carried down the chain. A slot that shifts when the enable is low, or fails to shift when it is high, shifts every later word by one position. The comparison against the bench's history model therefore catches it on the next sample from any slot past that point. The depth sweep reaches each slot directly, and the random depth walk checks that a new tap value is visible without waiting for an edge.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Width of a select field able to address n slots (at least one bit).
  function automatic int sel_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dly_chain.sv
module dly_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce,
  input  logic [WIDTH-1:0]              din,
  output logic [STAGES-1:0][WIDTH-1:0]  slots
);

  for (genvar k = 0; k < STAGES; k++) begin : g_slot
    logic [WIDTH-1:0] nxt;
    if (k == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = slots[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slots[k] <= '0;
      else if (ce) slots[k] <= nxt;
    end
  end

endmodule

// File: rtl/dly_tap_mux.sv
module dly_tap_mux #(
  parameter int WIDTH   = 8,
  parameter int STAGES  = 16,
  parameter int DEPTH_W = 4
) (
  input  logic [STAGES-1:0][WIDTH-1:0] slots,
  input  logic [DEPTH_W-1:0]           sel,
  output logic [WIDTH-1:0]             y
);

  // Select values past the last slot fall back to the last slot.
  always_comb begin
    y = slots[STAGES-1];
    for (int k = 0; k < STAGES; k++) begin
      if (sel == DEPTH_W'(k)) y = slots[k];
    end
  end

endmodule

// File: rtl/dly_out_stage.sv
module dly_out_stage #(
  parameter int WIDTH    = 8,
  parameter bit EXTRA_FF = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (EXTRA_FF) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= d;
    end
  end else begin : g_pass
    assign q = d;
  end

endmodule

// File: rtl/dly_line.sv
module dly_line #(
  parameter int WIDTH    = 8,
  parameter int STAGES   = 16,
  parameter bit EXTRA_FF = 1'b1,
  parameter int DEPTH_W  = dly_pkg::sel_bits(STAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_i,
  input  logic [WIDTH-1:0]   din_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [WIDTH-1:0]   tap_o,
  output logic [WIDTH-1:0]   casc_o,
  output logic [WIDTH-1:0]   tap_q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] slots;

  dly_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_i),
    .din   (din_i),
    .slots (slots)
  );

  dly_tap_mux #(.WIDTH(WIDTH), .STAGES(STAGES), .DEPTH_W(DEPTH_W)) u_mux (
    .slots (slots),
    .sel   (depth_i),
    .y     (tap_o)
  );

  dly_out_stage #(.WIDTH(WIDTH), .EXTRA_FF(EXTRA_FF)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_i),
    .d     (tap_o),
    .q     (tap_q_o)
  );

  assign casc_o = slots[LAST];

endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk #(
  parameter int WIDTH    = 8,
  parameter int STAGES   = 16,
  parameter bit EXTRA_FF = 1'b1,
  parameter int DEPTH_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_i,
  input logic [WIDTH-1:0]   din_i,
  input logic [DEPTH_W-1:0] depth_i,
  input logic [WIDTH-1:0]   tap_o,
  input logic [WIDTH-1:0]   casc_o,
  input logic [WIDTH-1:0]   tap_q_o
);

  AST_RST_CASC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> casc_o == '0); // R1

  AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ce_i) && depth_i == '0 |-> tap_o == $past(din_i)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(ce_i) && $stable(depth_i)
      |-> $stable(tap_o) && $stable(casc_o) && $stable(tap_q_o)); // R3

  AST_TAP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ce_i) && depth_i != '0
      && depth_i == $past(depth_i) + DEPTH_W'(1) |-> tap_o == $past(tap_o)); // R5

  AST_LAST_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    depth_i == DEPTH_W'(STAGES - 1) |-> tap_o == casc_o); // R6

  if (EXTRA_FF) begin : g_reg_chk
    AST_QREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ce_i) |-> tap_q_o == $past(tap_o)); // R7
  end else begin : g_pass_chk
    AST_QREG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      tap_q_o == tap_o); // R7
  end

endmodule

bind dly_line dly_line_chk #(
  .WIDTH(WIDTH), .STAGES(STAGES), .EXTRA_FF(EXTRA_FF), .DEPTH_W(DEPTH_W)
) u_chk (.*);

// File: tb/sim_dly_line.sv
module sim_dly_line;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 8;
  localparam int STAGES     = 16;
  localparam bit EXTRA_FF   = 1'b1;
  localparam int DEPTH_W    = 4;

  typedef struct {
    logic [WIDTH-1:0] tap;
    logic [WIDTH-1:0] casc;
    logic [WIDTH-1:0] q;
    string            tag;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ce_i = 1'b0;
  logic [WIDTH-1:0]   din_i = '0;
  logic [DEPTH_W-1:0] depth_i = '0;
  logic [WIDTH-1:0]   tap_o, casc_o, tap_q_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [WIDTH-1:0] hist [STAGES];
  logic [WIDTH-1:0] q_model;
  exp_t             exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_line #(.WIDTH(WIDTH), .STAGES(STAGES), .EXTRA_FF(EXTRA_FF)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .din_i(din_i), .depth_i(depth_i),
    .tap_o(tap_o), .casc_o(casc_o), .tap_q_o(tap_q_o)
  );

  task automatic cmp(input string req, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs
  // that should appear after the coming rising edge.
  task automatic step(input logic ce, input logic [WIDTH-1:0] d,
                      input logic [DEPTH_W-1:0] dep);
    exp_t e;
    @(negedge clk);
    ce_i = ce; din_i = d; depth_i = dep;
    #1;
    cmp("R5", "tap before edge", tap_o, hist[dep]);
    if (ce) begin
      if (EXTRA_FF) q_model = hist[dep];
      for (int k = STAGES - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
    end
    e.tap  = hist[dep];
    e.casc = hist[STAGES-1];
    e.q    = EXTRA_FF ? q_model : hist[dep];
    e.tag  = !ce ? "R3" : (dep == '0 ? "R2" : "R4");
    exp_q.push_back(e);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.tag, "tap_o", tap_o, e.tap);
      cmp(e.tag == "R3" ? "R3" : "R6", "casc_o", casc_o, e.casc);
      cmp(e.tag == "R3" ? "R3" : "R7", "tap_q_o", tap_q_o, e.q);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < STAGES; k++) hist[k] = '0;
    q_model = '0;
    ce_i = 1'b1; din_i = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "tap_o in reset", tap_o, '0);
    cmp("R1", "casc_o in reset", casc_o, '0);
    cmp("R1", "tap_q_o in reset", tap_q_o, '0);
    @(negedge clk);
    rst_n = 1'b1; ce_i = 1'b0;

    // Fixed depth sweep over every tap with random enable.
    for (int d = 0; d < STAGES; d++) begin
      for (int i = 0; i < 40; i++)
        step(($urandom % 10) < 7, WIDTH'($urandom), DEPTH_W'(d));
    end

    // Long idle stretch: nothing may move.
    for (int i = 0; i < 20; i++) step(1'b0, WIDTH'($urandom), 4'd9);

    // Random depth walk, including single steps upward across enabled edges.
    for (int i = 0; i < 400; i++) begin
      logic [DEPTH_W-1:0] dd;
      dd = (i % 3 == 0) ? depth_i + 4'd1 : DEPTH_W'($urandom);
      step(($urandom % 4) != 0, WIDTH'($urandom), dd);
    end

    // Deepest tap equals cascade output.
    for (int i = 0; i < 20; i++) step(1'b1, WIDTH'($urandom), 4'd15);

    @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule